// File: doc/BRIEF.md
# Autonomous Battery Charge Sequencer

This block steps a lithium-ion battery through one complete charge cycle without help from a host. It reads synchronous comparator flags about the battery and charger, a vector of blocking fault flags and a few host control bits. It decides which charge phase is active, selects the matching regulation target for the analog loop, and reports the phase as a 3-bit status code. The phases are trickle for a shorted pack, precharge for a deeply discharged pack, constant current, constant voltage (taper) and termination. After termination the cycle can start again.

A safety timer limits the length of a cycle. It counts a slow prescaled tick. When it expires it latches a fault, which ends the cycle and blocks new ones until the host clears it. After termination, a new cycle starts in one of two ways. It starts on its own when the battery falls below the recharge threshold. It also starts on a host edge: the inhibit bit falling, or the charge-current setting changing from zero to nonzero.

Top module: `chg_seq_top`

## Requirements
- R1: While `rst_n` is low and after its release, `phase_code` is 000, `phase_sel` is 0, `ilim_ma` is 0 and `tmr_fault` is 0.
- R2: A cycle leaves not-charging (000) only when all of the following hold in the same cycle: `conv_on`=1, `auto_en`=1, `inhibit`=0, `ichg_nz`=1, every `fault_vec` bit is 0 and `tmr_fault`=0. If any one of them fails, the code stays 000.
- R3: On a start, and on every cycle while in trickle or precharge, the phase is chosen as follows: `bat_lt_short`=1 gives trickle (001); otherwise `bat_lt_minsys`=1 gives precharge (010); otherwise the phase is constant current (011). Each change appears one clock after the input changes.
- R4: `phase_code` only ever takes the values 000, 001, 010, 011, 100 and 111. `phase_sel` is one-hot. Bit 0 marks trickle, bit 1 precharge, bit 2 constant current and bit 3 constant voltage. It is all zero in 000 and 111.
- R5: In constant current, `cv_reached`=1 moves the phase to constant voltage (100) at the next clock.
- R6: Constant voltage moves to termination done (111) only on a cycle where `i_lt_term`=1, `bat_gt_rechg`=1 and `dpm_active`=0 all hold. Any two of the three alone leave the phase at 100.
- R7: In any charging phase (001 to 100), losing any R2 start condition gives 000 one clock later. In 111, a fault bit, `conv_on`=0 or `auto_en`=0 gives 000. `inhibit`=1 or `ichg_nz`=0 leave the phase at 111.
- R8: In 111, with the R2 conditions met, `bat_gt_rechg`=0 starts a new cycle in the phase R3 selects.
- R9: In 111, with the R2 conditions met, a 1-to-0 edge of `inhibit` or a 0-to-1 edge of `ichg_nz` starts a new cycle in the phase R3 selects. No new cycle starts while neither edge occurs and `bat_gt_rechg`=1.
- R10: The safety timer counts `tick` cycles spent in a charging phase. At the TMR_LIMIT-th tick since the cycle started, `tmr_fault` rises at the next clock. The phase is 000 one clock later, and it stays 000 while the fault is held.
- R11: `tmr_fault` clears one clock after `timer_clr`=1 or `auto_en`=0. Every new cycle start resets the tick count to zero.
- R12: `ilim_ma` is IPRE_MA (default 384) in trickle and precharge, ITERM_MA (default 256) in constant voltage, and 0 in every other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_on | input | 1 | Power converter is running |
| auto_en | input | 1 | Host enable for autonomous charging |
| inhibit | input | 1 | Host charge inhibit |
| ichg_nz | input | 1 | Programmed charge current is nonzero |
| fault_vec | input | NFAULT | Blocking fault flags, any bit set blocks charging |
| bat_lt_short | input | 1 | Battery below short-circuit threshold |
| bat_lt_minsys | input | 1 | Battery below minimum system voltage setting |
| cv_reached | input | 1 | Charge voltage reached, regulation now voltage-limited |
| i_lt_term | input | 1 | Charge current below termination level |
| bat_gt_rechg | input | 1 | Battery above recharge threshold |
| dpm_active | input | 1 | Input dynamic power management is active |
| tick | input | 1 | Prescaled safety-timer tick |
| timer_clr | input | 1 | Host clear of the latched timer fault |
| phase_code | output | 3 | Charge phase status code |
| phase_sel | output | 4 | One-hot phase select for the regulator |
| ilim_ma | output | CUR_W | Current-select code for the active phase, in mA |
| tmr_fault | output | 1 | Latched safety-timer fault |

## Verification
The phase code, the phase select and the current code all come from one state register. They therefore change exactly one clock after the inputs that cause the change. The timer fault is its own register and also lands one clock after the deciding tick, and the abort it causes shows in the phase one clock after that. The bench drives inputs on the falling edge and samples on the next falling edge, so every check lands one rising edge after its stimulus. For the timer it counts rising edges exactly up to the limit, then checks the fault and the abort one edge apart.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'b000,
        PH_TRK  = 3'b001,
        PH_PRE  = 3'b010,
        PH_CC   = 3'b011,
        PH_CV   = 3'b100,
        PH_DONE = 3'b111
    } phase_e;

    function automatic logic is_charging(phase_e p);
        return (p == PH_TRK) || (p == PH_PRE) || (p == PH_CC) || (p == PH_CV);
    endfunction

endpackage

// File: rtl/chg_seq_gate.sv
module chg_seq_gate #(
    parameter int NFAULT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_on,
    input  logic              auto_en,
    input  logic              inhibit,
    input  logic              ichg_nz,
    input  logic [NFAULT-1:0] fault_vec,
    input  logic              tmr_fault,
    output logic              run_ok,
    output logic              hold_ok,
    output logic              host_kick
);

    typedef struct packed {
        logic inh;
        logic nz;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d     = hist_q;
        hist_d.inh = inhibit;
        hist_d.nz  = ichg_nz;

        // Conditions that allow the done phase to persist
        hold_ok   = conv_on && auto_en && (fault_vec == '0);
        // Full start / continue permission
        run_ok    = hold_ok && !inhibit && ichg_nz && !tmr_fault;
        // Host edges that re-arm a cycle after termination
        host_kick = (hist_q.inh && !inhibit) || (!hist_q.nz && ichg_nz);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

endmodule

// File: rtl/chg_seq_timer.sv
module chg_seq_timer #(
    parameter int unsigned LIMIT = 43200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic charging,
    input  logic start,
    input  logic clr,
    output logic fault
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = '0;
        end else if (charging && tick && !tmr_q.flt) begin
            if (tmr_q.cnt == LAST) tmr_d.flt = 1'b1;
            else                   tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        if (clr) tmr_d.flt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign fault = tmr_q.flt;

endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
    import chg_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_ok,
    input  logic   hold_ok,
    input  logic   host_kick,
    input  logic   bat_lt_short,
    input  logic   bat_lt_minsys,
    input  logic   cv_reached,
    input  logic   i_lt_term,
    input  logic   bat_gt_rechg,
    input  logic   dpm_active,
    output phase_e phase,
    output logic   charging,
    output logic   start
);

    typedef struct packed {
        phase_e ph;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    phase_e entry_ph;
    logic   term_ok;

    always_comb begin
        fsm_d    = fsm_q;
        entry_ph = bat_lt_short  ? PH_TRK :
                   bat_lt_minsys ? PH_PRE : PH_CC;
        term_ok  = i_lt_term && bat_gt_rechg && !dpm_active;

        case (fsm_q.ph)
            PH_IDLE: if (run_ok) fsm_d.ph = entry_ph;
            PH_TRK, PH_PRE: begin
                if (!run_ok) fsm_d.ph = PH_IDLE;
                else         fsm_d.ph = entry_ph;
            end
            PH_CC: begin
                if (!run_ok)        fsm_d.ph = PH_IDLE;
                else if (cv_reached) fsm_d.ph = PH_CV;
            end
            PH_CV: begin
                if (!run_ok)     fsm_d.ph = PH_IDLE;
                else if (term_ok) fsm_d.ph = PH_DONE;
            end
            PH_DONE: begin
                if (!hold_ok)
                    fsm_d.ph = PH_IDLE;
                else if (run_ok && (!bat_gt_rechg || host_kick))
                    fsm_d.ph = entry_ph;
            end
            default: fsm_d.ph = PH_IDLE;
        endcase

        start = is_charging(fsm_d.ph) && !is_charging(fsm_q.ph);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q.ph <= PH_IDLE;
        else        fsm_q    <= fsm_d;
    end

    assign phase    = fsm_q.ph;
    assign charging = is_charging(fsm_q.ph);

endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
    import chg_seq_pkg::*;
#(
    parameter int          NFAULT    = 8,
    parameter int unsigned TMR_LIMIT = 43200,
    parameter int          CUR_W     = 12,
    parameter int          IPRE_MA   = 384,
    parameter int          ITERM_MA  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_on,
    input  logic              auto_en,
    input  logic              inhibit,
    input  logic              ichg_nz,
    input  logic [NFAULT-1:0] fault_vec,
    input  logic              bat_lt_short,
    input  logic              bat_lt_minsys,
    input  logic              cv_reached,
    input  logic              i_lt_term,
    input  logic              bat_gt_rechg,
    input  logic              dpm_active,
    input  logic              tick,
    input  logic              timer_clr,
    output logic [2:0]        phase_code,
    output logic [3:0]        phase_sel,
    output logic [CUR_W-1:0]  ilim_ma,
    output logic              tmr_fault
);

    localparam logic [CUR_W-1:0] PRE_CODE  = CUR_W'(IPRE_MA);
    localparam logic [CUR_W-1:0] TERM_CODE = CUR_W'(ITERM_MA);

    logic   run_ok, hold_ok, host_kick;
    logic   charging, start;
    phase_e phase;

    chg_seq_gate #(.NFAULT(NFAULT)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_on   (conv_on),
        .auto_en   (auto_en),
        .inhibit   (inhibit),
        .ichg_nz   (ichg_nz),
        .fault_vec (fault_vec),
        .tmr_fault (tmr_fault),
        .run_ok    (run_ok),
        .hold_ok   (hold_ok),
        .host_kick (host_kick)
    );

    chg_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_ok        (run_ok),
        .hold_ok       (hold_ok),
        .host_kick     (host_kick),
        .bat_lt_short  (bat_lt_short),
        .bat_lt_minsys (bat_lt_minsys),
        .cv_reached    (cv_reached),
        .i_lt_term     (i_lt_term),
        .bat_gt_rechg  (bat_gt_rechg),
        .dpm_active    (dpm_active),
        .phase         (phase),
        .charging      (charging),
        .start         (start)
    );

    chg_seq_timer #(.LIMIT(TMR_LIMIT)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .charging (charging),
        .start    (start),
        .clr      (timer_clr || !auto_en),
        .fault    (tmr_fault)
    );

    always_comb begin
        phase_code = phase;
        phase_sel  = '0;
        ilim_ma    = '0;
        case (phase)
            PH_TRK: begin phase_sel[0] = 1'b1; ilim_ma = PRE_CODE;  end
            PH_PRE: begin phase_sel[1] = 1'b1; ilim_ma = PRE_CODE;  end
            PH_CC:  begin phase_sel[2] = 1'b1;                      end
            PH_CV:  begin phase_sel[3] = 1'b1; ilim_ma = TERM_CODE; end
            default: ;
        endcase
    end

endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk #(
    parameter int NFAULT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_en,
    input logic [NFAULT-1:0] fault_vec,
    input logic              i_lt_term,
    input logic              bat_gt_rechg,
    input logic              dpm_active,
    input logic              timer_clr,
    input logic [2:0]        phase_code,
    input logic [3:0]        phase_sel,
    input logic              tmr_fault
);

    logic chg_now;
    assign chg_now = (phase_code >= 3'b001) && (phase_code <= 3'b100);

    p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code != 3'b101) && (phase_code != 3'b110));

    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_sel) && (chg_now == (phase_sel != 4'b0)));

    p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == 3'b000 && !auto_en) |=> phase_code == 3'b000);

    p_term_three_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == 3'b100 && !(i_lt_term && bat_gt_rechg && !dpm_active))
        |=> phase_code != 3'b111);

    p_fault_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_now && fault_vec != '0) |=> phase_code == 3'b000);

    p_tmr_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fault |=> !((phase_code >= 3'b001) && (phase_code <= 3'b100)));

    p_tmr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_clr || !auto_en) |=> !tmr_fault);

endmodule

bind chg_seq_top chg_seq_chk #(.NFAULT(NFAULT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_en      (auto_en),
    .fault_vec    (fault_vec),
    .i_lt_term    (i_lt_term),
    .bat_gt_rechg (bat_gt_rechg),
    .dpm_active   (dpm_active),
    .timer_clr    (timer_clr),
    .phase_code   (phase_code),
    .phase_sel    (phase_sel),
    .tmr_fault    (tmr_fault)
);

// File: tb/tb_chg_seq_top.sv
`timescale 1ns/1ps
module tb_chg_seq_top;

    localparam int NF    = 8;
    localparam int LIM   = 20;
    localparam int CUR_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_on, auto_en, inhibit, ichg_nz;
    logic [NF-1:0] fault_vec;
    logic bat_lt_short, bat_lt_minsys, cv_reached, i_lt_term, bat_gt_rechg, dpm_active;
    logic tick, timer_clr;
    logic [2:0] phase_code;
    logic [3:0] phase_sel;
    logic [CUR_W-1:0] ilim_ma;
    logic tmr_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    chg_seq_top #(.NFAULT(NF), .TMR_LIMIT(LIM), .CUR_W(CUR_W)) dut (
        .clk(clk), .rst_n(rst_n), .conv_on(conv_on), .auto_en(auto_en),
        .inhibit(inhibit), .ichg_nz(ichg_nz), .fault_vec(fault_vec),
        .bat_lt_short(bat_lt_short), .bat_lt_minsys(bat_lt_minsys),
        .cv_reached(cv_reached), .i_lt_term(i_lt_term), .bat_gt_rechg(bat_gt_rechg),
        .dpm_active(dpm_active), .tick(tick), .timer_clr(timer_clr),
        .phase_code(phase_code), .phase_sel(phase_sel), .ilim_ma(ilim_ma),
        .tmr_fault(tmr_fault)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_sel(logic [2:0] ph);
        case (ph)
            3'b001: return 1; 3'b010: return 2; 3'b011: return 4; 3'b100: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_ilim(logic [2:0] ph);
        case (ph)
            3'b001, 3'b010: return 384; 3'b100: return 256;
            default: return 0;
        endcase
    endfunction

    task automatic chk_ph(string req, logic [2:0] exp);
        chk(req, "phase_code", int'(phase_code), int'(exp));
        chk("R4", "phase_sel", int'(phase_sel), exp_sel(exp));
        chk("R12", "ilim_ma", int'(ilim_ma), exp_ilim(exp));
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ok();
        conv_on = 1; auto_en = 1; inhibit = 0; ichg_nz = 1; fault_vec = '0;
        bat_lt_short = 0; bat_lt_minsys = 0; cv_reached = 0;
        i_lt_term = 0; bat_gt_rechg = 0; dpm_active = 0; tick = 0; timer_clr = 0;
    endtask

    task automatic go_idle();
        auto_en = 0; step(); set_ok(); auto_en = 0;
        chk_ph("R7", 3'b000);
    endtask

    // From constant current, reach termination done
    task automatic cc_to_done();
        cv_reached = 1; step(); chk_ph("R5", 3'b100);
        cv_reached = 0; i_lt_term = 1; bat_gt_rechg = 1; dpm_active = 0;
        step(); chk_ph("R6", 3'b111);
        i_lt_term = 0;
    endtask

    task automatic t_reset();
        conv_on = 0; auto_en = 0; inhibit = 0; ichg_nz = 0; fault_vec = '0;
        bat_lt_short = 0; bat_lt_minsys = 0; cv_reached = 0; i_lt_term = 0;
        bat_gt_rechg = 0; dpm_active = 0; tick = 0; timer_clr = 0;
        rst_n = 0; step(); step();
        chk_ph("R1", 3'b000);
        chk("R1", "tmr_fault", int'(tmr_fault), 0);
        rst_n = 1; step();
        chk_ph("R1", 3'b000);
        chk("R1", "tmr_fault", int'(tmr_fault), 0);
    endtask

    task automatic t_gating();
        set_ok(); auto_en = 0; step(); chk_ph("R2", 3'b000);
        set_ok(); inhibit = 1; step(); chk_ph("R2", 3'b000);
        set_ok(); ichg_nz = 0; step(); chk_ph("R2", 3'b000);
        set_ok(); conv_on = 0; step(); chk_ph("R2", 3'b000);
        for (int i = 0; i < NF; i++) begin
            set_ok(); fault_vec[i] = 1'b1; step(); chk_ph("R2", 3'b000);
        end
        set_ok(); step(); chk_ph("R2", 3'b011);
        go_idle();
    endtask

    task automatic t_select();
        set_ok(); bat_lt_short = 1; bat_lt_minsys = 1;
        step(); chk_ph("R3", 3'b001);
        bat_lt_short = 0; step(); chk_ph("R3", 3'b010);
        bat_lt_minsys = 0; step(); chk_ph("R3", 3'b011);
    endtask

    task automatic t_terminate();
        cv_reached = 1; step(); chk_ph("R5", 3'b100);
        cv_reached = 0;
        i_lt_term = 1; bat_gt_rechg = 1; dpm_active = 1; step(); chk_ph("R6", 3'b100);
        dpm_active = 0; bat_gt_rechg = 0; step(); chk_ph("R6", 3'b100);
        bat_gt_rechg = 1; i_lt_term = 0; step(); chk_ph("R6", 3'b100);
        i_lt_term = 1; step(); chk_ph("R6", 3'b111);
        i_lt_term = 0;
    endtask

    task automatic t_done_hold_and_host();
        // now in 111 with bat_gt_rechg=1
        step(); chk_ph("R9", 3'b111);
        inhibit = 1; step(); chk_ph("R7", 3'b111);
        step(); chk_ph("R7", 3'b111);
        inhibit = 0; step(); chk_ph("R9", 3'b011);
        cc_to_done();
        ichg_nz = 0; step(); chk_ph("R7", 3'b111);
        ichg_nz = 1; step(); chk_ph("R9", 3'b011);
        cc_to_done();
        fault_vec[3] = 1; step(); chk_ph("R7", 3'b000);
        fault_vec = '0; step(); chk_ph("R2", 3'b011);
        cc_to_done();
        auto_en = 0; step(); chk_ph("R7", 3'b000);
        set_ok(); step(); chk_ph("R2", 3'b011);
    endtask

    task automatic t_recharge();
        cc_to_done();
        bat_lt_minsys = 1; step(); chk_ph("R8", 3'b111);
        bat_gt_rechg = 0; step(); chk_ph("R8", 3'b010);
        bat_lt_minsys = 0; step(); chk_ph("R3", 3'b011);
    endtask

    task automatic t_abort();
        for (int i = 0; i < NF; i++) begin
            fault_vec = '0; fault_vec[i] = 1'b1; step(); chk_ph("R7", 3'b000);
            fault_vec = '0; step(); chk_ph("R2", 3'b011);
        end
        inhibit = 1; step(); chk_ph("R7", 3'b000);
        inhibit = 0; step(); chk_ph("R2", 3'b011);
        cv_reached = 1; step(); chk_ph("R5", 3'b100);
        cv_reached = 0; conv_on = 0; step(); chk_ph("R7", 3'b000);
        conv_on = 1; step(); chk_ph("R2", 3'b011);
    endtask

    task automatic t_timer();
        go_idle();
        set_ok(); step(); chk_ph("R2", 3'b011);
        tick = 1;
        repeat (LIM - 1) step();
        chk("R10", "tmr_fault before limit", int'(tmr_fault), 0);
        chk_ph("R10", 3'b011);
        step();
        chk("R10", "tmr_fault at limit", int'(tmr_fault), 1);
        chk_ph("R10", 3'b011);
        step(); chk_ph("R10", 3'b000);
        tick = 0;
        step(); step(); chk_ph("R10", 3'b000);
        chk("R10", "tmr_fault held", int'(tmr_fault), 1);
        timer_clr = 1; step(); timer_clr = 0;
        chk("R11", "tmr_fault after clear", int'(tmr_fault), 0);
        chk_ph("R10", 3'b000);
        step(); chk_ph("R11", 3'b011);
        tick = 1;
        repeat (LIM - 1) step();
        chk("R11", "count restarted", int'(tmr_fault), 0);
        step();
        chk("R10", "tmr_fault second expiry", int'(tmr_fault), 1);
        tick = 0; auto_en = 0; step(); auto_en = 1;
        chk("R11", "tmr_fault after enable drop", int'(tmr_fault), 0);
        chk_ph("R7", 3'b000);
        step(); chk_ph("R11", 3'b011);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        step();
        t_reset();
        t_gating();
        t_select();
        t_terminate();
        t_done_hold_and_host();
        t_recharge();
        t_abort();
        t_timer();
        finished = 1;
        finish_run();
    end

endmodule